// File: doc/BRIEF.md
# Cascaded Match Priority Arbiter

This block sits in each of up to eight search devices that share one result bus in a depth cascade. Each device sees the outcome of its own table search (hit, hit location, several-hits flag) and a match-in line. Match-in is the OR of the match-out lines of every device of higher priority. From these the block decides whether this device places its result on the shared index bus. It tells lower-priority devices that it hit, and it joins a shared, active-low, open-drain multi-hit line. The table itself is outside the block.

One device carries a "last" strap and returns the completion handshake to the host. A device with the "last SRAM" strap drives the external SRAM enables. That device also holds the index bus whenever no other device wins, so the bus never floats. The straps must go to the lowest-priority device of the chain. Three-state behaviour is shown as an output-enable and data pair for each bus. The open-drain line is shown as a pull request, which board logic combines into a wired-AND with a pull-up.

A lookup presented in cycle t shows on match-out after the clock edge that ends cycle t. The device samples match-in one cycle later. The bus, handshake and SRAM outputs change after the second edge. Every output is a register.

Top module: `casc_match_arb`

## Requirements
- R1: While reset is high, and in the cycle after it, every output-enable (idx_oe, fb_oe, sram_oe) is low, match_out is low and mm_pull is low.
- R2: Reset clears the device enable bit. While the bit is clear, lookups and write requests are ignored: match_out stays low and no index is driven. A pulse on en_set sets the bit from the next cycle.
- R3: For a lookup with local_hit high in cycle t, match_out is high in cycle t+1 and low otherwise. Match_out reflects only the local hit.
- R4: A device whose lookup hit and whose match_in is low in cycle t+1 drives idx_oe high in cycle t+2. Its idx_data is {dev_addr, lookup_type, local_loc}, with dev_addr in the top DEV_W bits and local_loc in the low LOC_W bits.
- R5: A device that hit while match_in is high keeps idx_oe low and sets mm_pull in cycle t+2.
- R6: A device that hit with local_multi high sets mm_pull in cycle t+2. local_multi without a hit has no effect.
- R7: The last-SRAM device drives idx_oe with idx_data all zero whenever it has not won and match_in is low. This covers idle cycles and lookups that missed in every device, so exactly one enabled device drives the bus.
- R8: Only the last-SRAM device raises sram_oe once enabled. Its sram_ce is high in cycle t+2 when any device in the cascade hit or sram_wr was high in cycle t. Its sram_we is high in cycle t+2 exactly when sram_wr was high.
- R9: Only the last device raises fb_oe once enabled. Its ack_valid is high in cycle t+2 for every completed lookup, including misses. Its ack_hit is high when any device in the cascade hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Sets the device enable bit |
| dev_addr | input | DEV_W | Static device address strap |
| last_dev | input | 1 | Strap: this device returns the host handshake |
| last_sram | input | 1 | Strap: this device drives SRAM control and default bus |
| lookup_done | input | 1 | Local search result valid this cycle |
| local_hit | input | 1 | Local search found a match |
| local_multi | input | 1 | Local search found more than one match |
| sram_wr | input | 1 | SRAM write request this cycle |
| lookup_type | input | TYPE_W | Lookup type tag of the request |
| local_loc | input | LOC_W | Highest-priority local hit location |
| match_in | input | 1 | OR of higher-priority match-out lines |
| match_out | output | 1 | Local hit to lower-priority devices |
| idx_oe | output | 1 | Index bus drive enable |
| idx_data | output | DEV_W+TYPE_W+LOC_W | Index bus value |
| mm_pull | output | 1 | Pulls the shared active-low multi-hit line low |
| fb_oe | output | 1 | Handshake drive enable |
| ack_valid | output | 1 | Lookup completed |
| ack_hit | output | 1 | Some device in the cascade hit |
| sram_oe | output | 1 | SRAM control drive enable |
| sram_ce | output | 1 | SRAM chip/output enable |
| sram_we | output | 1 | SRAM write enable |

## Verification
The hardest situation to reach is a cascade-wide conflict. Two or three devices hit in the same lookup, and each device's decision hangs on the registered match-out of the others one cycle earlier. One device cannot show this alone, so the bench builds a three-device chain with straps on the lowest device. It models the match-in OR and the pulled-up wired-AND multi-hit line, then walks a table of hit patterns that covers single winners at every rank, two-way and three-way conflicts, a local multi-hit and a miss with a write. For each pattern the bench checks which device owns the bus, the index it carries and the shared line.

// File: rtl/cmpa_pkg.sv
package cmpa_pkg;
  typedef struct packed {
    logic valid;
    logic hit;
    logic multi;
    logic wr;
  } stage_flags_t;
endpackage

// File: rtl/cmpa_enable.sv
module cmpa_enable (
  input  logic clk,
  input  logic rst,
  input  logic en_set,
  output logic en
);
  always_ff @(posedge clk) begin
    if (rst)         en <= 1'b0;
    else if (en_set) en <= 1'b1;
  end
endmodule

// File: rtl/cmpa_stage.sv
module cmpa_stage
  import cmpa_pkg::*;
#(
  parameter int TYPE_W = 2,
  parameter int LOC_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              lookup_done,
  input  logic              local_hit,
  input  logic              local_multi,
  input  logic              sram_wr,
  input  logic [TYPE_W-1:0] lookup_type,
  input  logic [LOC_W-1:0]  local_loc,
  output stage_flags_t      flags,
  output logic [TYPE_W-1:0] s1_type,
  output logic [LOC_W-1:0]  s1_loc,
  output logic              match_out
);
  logic take;
  assign take = en & lookup_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      s1_type   <= '0;
      s1_loc    <= '0;
      match_out <= 1'b0;
    end else begin
      flags.valid <= take;
      flags.hit   <= take & local_hit;
      flags.multi <= take & local_multi;
      flags.wr    <= en & sram_wr;
      match_out   <= take & local_hit;
      if (take) begin
        s1_type <= lookup_type;
        s1_loc  <= local_loc;
      end
    end
  end

  // R2: nothing is captured while the enable bit is clear
  assert_disabled_ignores_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!flags.valid && !flags.wr && !match_out));
endmodule

// File: rtl/cmpa_outreg.sv
module cmpa_outreg
  import cmpa_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int TYPE_W = 2,
  parameter int LOC_W  = 18,
  localparam int IDX_W = DEV_W + TYPE_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              last_dev,
  input  logic              last_sram,
  input  logic [DEV_W-1:0]  dev_addr,
  input  stage_flags_t      flags,
  input  logic [TYPE_W-1:0] s1_type,
  input  logic [LOC_W-1:0]  s1_loc,
  input  logic              match_in,
  output logic              idx_oe,
  output logic [IDX_W-1:0]  idx_data,
  output logic              mm_pull,
  output logic              fb_oe,
  output logic              ack_valid,
  output logic              ack_hit,
  output logic              sram_oe,
  output logic              sram_ce,
  output logic              sram_we
);
  logic win, any_hit, dflt;
  assign win     = flags.valid & flags.hit & ~match_in;
  assign any_hit = flags.valid & (flags.hit | match_in);
  assign dflt    = last_sram & ~match_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_oe    <= 1'b0;
      idx_data  <= '0;
      mm_pull   <= 1'b0;
      fb_oe     <= 1'b0;
      ack_valid <= 1'b0;
      ack_hit   <= 1'b0;
      sram_oe   <= 1'b0;
      sram_ce   <= 1'b0;
      sram_we   <= 1'b0;
    end else begin
      idx_oe    <= en & (win | dflt);
      idx_data  <= win ? {dev_addr, s1_type, s1_loc} : '0;
      mm_pull   <= flags.valid & flags.hit & (match_in | flags.multi);
      fb_oe     <= en & last_dev;
      ack_valid <= en & last_dev & flags.valid;
      ack_hit   <= en & last_dev & any_hit;
      sram_oe   <= en & last_sram;
      sram_ce   <= en & last_sram & (any_hit | flags.wr);
      sram_we   <= en & last_sram & flags.wr;
    end
  end

  // R5: a lower-priority hit stays off the bus and flags the conflict
  assert_yield_to_upstream_R5: assert property (@(posedge clk) disable iff (rst)
    (flags.valid && flags.hit && match_in) |=> (!idx_oe && mm_pull));
  // R4: an unblocked hit takes the bus
  assert_winner_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (en && flags.valid && flags.hit && !match_in) |=> idx_oe);
  // R8: SRAM control only from the strapped device
  assert_sram_owner_R8: assert property (@(posedge clk) disable iff (rst)
    (sram_oe || sram_ce || sram_we) |-> last_sram);
  // R9: handshake only from the strapped device
  assert_fb_owner_R9: assert property (@(posedge clk) disable iff (rst)
    (fb_oe || ack_valid || ack_hit) |-> last_dev);
endmodule

// File: rtl/casc_match_arb.sv
module casc_match_arb
  import cmpa_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int TYPE_W = 2,
  parameter int LOC_W  = 18
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en_set,
  input  logic [DEV_W-1:0]              dev_addr,
  input  logic                          last_dev,
  input  logic                          last_sram,
  input  logic                          lookup_done,
  input  logic                          local_hit,
  input  logic                          local_multi,
  input  logic                          sram_wr,
  input  logic [TYPE_W-1:0]             lookup_type,
  input  logic [LOC_W-1:0]              local_loc,
  input  logic                          match_in,
  output logic                          match_out,
  output logic                          idx_oe,
  output logic [DEV_W+TYPE_W+LOC_W-1:0] idx_data,
  output logic                          mm_pull,
  output logic                          fb_oe,
  output logic                          ack_valid,
  output logic                          ack_hit,
  output logic                          sram_oe,
  output logic                          sram_ce,
  output logic                          sram_we
);
  logic              en;
  stage_flags_t      flags;
  logic [TYPE_W-1:0] s1_type;
  logic [LOC_W-1:0]  s1_loc;

  cmpa_enable u_en (
    .clk(clk), .rst(rst), .en_set(en_set), .en(en)
  );

  cmpa_stage #(.TYPE_W(TYPE_W), .LOC_W(LOC_W)) u_stage (
    .clk(clk), .rst(rst), .en(en),
    .lookup_done(lookup_done), .local_hit(local_hit),
    .local_multi(local_multi), .sram_wr(sram_wr),
    .lookup_type(lookup_type), .local_loc(local_loc),
    .flags(flags), .s1_type(s1_type), .s1_loc(s1_loc),
    .match_out(match_out)
  );

  cmpa_outreg #(.DEV_W(DEV_W), .TYPE_W(TYPE_W), .LOC_W(LOC_W)) u_out (
    .clk(clk), .rst(rst), .en(en),
    .last_dev(last_dev), .last_sram(last_sram), .dev_addr(dev_addr),
    .flags(flags), .s1_type(s1_type), .s1_loc(s1_loc),
    .match_in(match_in),
    .idx_oe(idx_oe), .idx_data(idx_data), .mm_pull(mm_pull),
    .fb_oe(fb_oe), .ack_valid(ack_valid), .ack_hit(ack_hit),
    .sram_oe(sram_oe), .sram_ce(sram_ce), .sram_we(sram_we)
  );

  // R1: outputs released after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!idx_oe && !fb_oe && !sram_oe && !match_out && !mm_pull));
  // R3: a local hit raises match-out on the next cycle
  assert_match_out_R3: assert property (@(posedge clk) disable iff (rst)
    (en && lookup_done && local_hit) |=> match_out);
endmodule

// File: tb/casc_match_arb_tb_top.sv
module casc_match_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND     = 3;
  localparam int DEV_W  = 3;
  localparam int TYPE_W = 2;
  localparam int LOC_W  = 18;
  localparam int IDX_W  = DEV_W + TYPE_W + LOC_W;
  localparam int NVEC   = 9;
  localparam int WD_LIMIT = 5000;

  // entry: [11:9] hits (bit i = device i), [8:6] local multi, [5:4] type,
  // [3] sram write, [2:1] expected winner (3 = none), [0] expected multi-hit
  localparam logic [11:0] VEC [NVEC] = '{
    12'b000_000_00_0_11_0,
    12'b001_000_01_0_00_0,
    12'b010_000_10_0_01_0,
    12'b100_000_11_0_10_0,
    12'b011_000_01_0_00_1,
    12'b110_000_00_0_01_1,
    12'b100_100_10_0_10_1,
    12'b000_010_11_1_11_0,
    12'b111_000_10_0_00_1
  };
  localparam logic [DEV_W-1:0] ADDR [ND] = '{3'd5, 3'd2, 3'd7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_set = 1'b0;
  logic lookup_done = 1'b0;
  logic sram_wr = 1'b0;
  logic [TYPE_W-1:0] ltype = '0;
  logic [ND-1:0] hit = '0, multi = '0;
  logic [LOC_W-1:0] loc [ND];
  logic [ND-1:0] mo, mi, oe, mmp, fbo, akv, akh, so, sce, swe;
  logic [IDX_W-1:0] idx [ND];
  logic mm_line;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mi[0] = 1'b0;
  assign mi[1] = mo[0];
  assign mi[2] = mo[0] | mo[1];
  assign mm_line = ~|mmp;   // pull-up with open-drain pulls

  for (genvar i = 0; i < ND; i++) begin : g_dev
    casc_match_arb #(.DEV_W(DEV_W), .TYPE_W(TYPE_W), .LOC_W(LOC_W)) dut_i (
      .clk(clk), .rst(rst), .en_set(en_set), .dev_addr(ADDR[i]),
      .last_dev(i == ND-1), .last_sram(i == ND-1),
      .lookup_done(lookup_done), .local_hit(hit[i]), .local_multi(multi[i]),
      .sram_wr(sram_wr), .lookup_type(ltype), .local_loc(loc[i]),
      .match_in(mi[i]), .match_out(mo[i]), .idx_oe(oe[i]), .idx_data(idx[i]),
      .mm_pull(mmp[i]), .fb_oe(fbo[i]), .ack_valid(akv[i]), .ack_hit(akh[i]),
      .sram_oe(so[i]), .sram_ce(sce[i]), .sram_we(swe[i])
    );
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] bus_val();
    logic [IDX_W-1:0] v = '0;
    for (int i = 0; i < ND; i++) if (oe[i]) v = idx[i];
    return v;
  endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<%0d", cycles, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ND; i++) loc[i] = '0;
    @(negedge clk); tick(); tick();
    // R1: reset state
    chk("R1 idx_oe", 64'(oe), 0);
    chk("R1 fb/sram oe", 64'({fbo, so}), 0);
    chk("R1 match_out", 64'(mo), 0);
    chk("R1 mm line high", 64'(mm_line), 1);
    rst = 1'b0;
    // R2: lookup before enable is ignored
    hit = 3'b111; lookup_done = 1'b1; sram_wr = 1'b1;
    tick();
    hit = '0; lookup_done = 1'b0; sram_wr = 1'b0;
    chk("R2 match_out while disabled", 64'(mo), 0);
    tick();
    chk("R2 no drive while disabled", 64'({oe, sce, mmp}), 0);
    en_set = 1'b1; tick(); en_set = 1'b0; tick();
    // R7 idle default driver, R8/R9 ownership
    chk("R7 idle single driver", 64'(oe), 64'b100);
    chk("R7 idle value", 64'(bus_val()), 0);
    chk("R8 sram_oe owner", 64'(so), 64'b100);
    chk("R9 fb_oe owner", 64'(fbo), 64'b100);
    chk("R9 idle ack_valid", 64'(akv), 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [11:0] v = VEC[k];
      logic [IDX_W-1:0] exp_idx;
      int w = int'(v[2:1]);
      hit = v[11:9]; multi = v[8:6]; ltype = v[5:4]; sram_wr = v[3];
      lookup_done = 1'b1;
      for (int i = 0; i < ND; i++) loc[i] = LOC_W'(32'h1000 * (i + 1) + k);
      exp_idx = (w < ND) ? {ADDR[w], v[5:4], loc[w]} : '0;
      tick();
      lookup_done = 1'b0; hit = '0; multi = '0; sram_wr = 1'b0;
      chk($sformatf("R3 match_out vec%0d", k), 64'(mo), 64'(v[11:9]));
      tick();
      chk($sformatf("R4 R7 one driver vec%0d", k), 64'($countones(oe)), 1);
      chk($sformatf("R4 R7 index vec%0d", k), 64'(bus_val()), 64'(exp_idx));
      chk($sformatf("R5 R6 mm line vec%0d", k), 64'(mm_line), 64'(!v[0]));
      chk($sformatf("R9 ack vec%0d", k), 64'({akv[2], akh[2]}), 64'({1'b1, |v[11:9]}));
      chk($sformatf("R8 sram ce/we vec%0d", k), 64'({sce[2], swe[2]}),
          64'({(|v[11:9]) | v[3], v[3]}));
      if (w < ND) chk($sformatf("R4 winner oe vec%0d", k), 64'(oe[w]), 1);
    end
    // R5: dev1 blocked by dev0 in vec4 checked above; explicit look at dev1 oe
    hit = 3'b011; lookup_done = 1'b1; tick(); lookup_done = 1'b0; hit = '0; tick();
    chk("R5 blocked device off bus", 64'(oe[1]), 0);
    chk("R5 blocked device pulls", 64'(mmp[1]), 1);
    chk("R6 winner no pull", 64'(mmp[0]), 0);
    // R1/R2: reset after enable clears the bit
    rst = 1'b1; tick();
    rst = 1'b0;
    chk("R1 reset releases bus", 64'({oe, fbo, so}), 0);
    hit = 3'b001; lookup_done = 1'b1; tick(); lookup_done = 1'b0; hit = '0;
    chk("R2 enable cleared by reset", 64'(mo), 0);
    tick();
    chk("R2 no drive after reset", 64'(oe), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule